// File: doc/BRIEF.md
# 16-Bit Timer with Edge Capture

This block is a 16-bit up-counter with a snapshot register. The counter's increment source is chosen by software. It can step once per system clock, once every twelve system clocks, or once per falling edge on an external count pin. A falling edge on a second pin copies the live count into a capture register, but only when capture is enabled. A wrap of the counter from all-ones to zero sets a sticky overflow flag. That flag drives a level interrupt, gated by an enable input.

Software reaches the counter, the capture register and a control register through a simple synchronous write port and a combinational read port. Both external pins pass through a two-flop synchroniser. Each pin then feeds a two-state edge tracker:

- LVL_LOW moves to LVL_HIGH on a rise transition.
- LVL_HIGH moves to LVL_LOW on a fall transition, and that transition emits a one-cycle pulse.

The source selector decodes four count modes from the control fields and the divide select:

- SRC_HALT
- SRC_SYSCLK
- SRC_DIV12
- SRC_PIN

Top module: `tmr16_capture`

## Requirements
- R1: After reset the count, the capture register and the control register read zero, and irq is 0.
- R2: Register select on addr: 0 is the count (read/write), 1 is the capture register (read-only, writes ignored), 2 is the control register, and 3 reads zero. Control fields: bit 0 mode select, bit 1 source select, bit 2 run, bit 3 capture enable, bit 7 overflow flag. Other control bits read zero. A write takes effect at the clock edge where wr_en is 1.
- R3: The counter advances only while control bits 0 and 2 are both 1. Otherwise it holds.
- R4: With bit 1 = 0 and div12_sel = 0, the count rises by one on every clock.
- R5: With bit 1 = 0 and div12_sel = 1, the count rises once every 12 clocks. The first step lands on the 12th edge after run becomes active. The prescaler restarts from zero whenever counting is inactive.
- R6: With bit 1 = 1, each falling edge of cnt_pin adds one. A level change made between edges k-1 and k is stepped in at edge k+2.
- R7: A falling edge on cap_pin, with the same synchroniser latency as R6, copies the count into the capture register. If the count steps in that same cycle, the value from before the step is captured.
- R8: When bit 3 is 0, edges on cap_pin leave the capture register unchanged.
- R9: A wrap from 0xFFFF to 0x0000 sets bit 7. Bit 7 stays set until software writes it to 0.
- R10: If a wrap and a control write clearing bit 7 fall on the same edge, bit 7 ends up set.
- R11: irq equals bit 7 AND irq_en, as a level.
- R12: A count write on an edge where the counter would also step loads the written value, and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| div12_sel | input | 1 | 1 = system clock divided by 12 as timer source |
| irq_en | input | 1 | Interrupt enable |
| cnt_pin | input | 1 | External count input, falling-edge active |
| cap_pin | input | 1 | Capture trigger, falling-edge active |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land on one edge. The first pair is a capture edge together with a counter step. The second pair is a counter wrap together with a software write to the control or count register.

The first pair is provoked in two ways. One is pulsing cap_pin while the counter steps every clock. The other is dropping cnt_pin and cap_pin on the same cycle in pin mode.

The second pair is provoked by loading 0xFFFE and issuing a flag clear exactly on the wrap edge, and by rewriting 0xFFFF into a running counter.

A behavioural model advances on every edge using plain integer rules from the requirements. It judges the captured value, the flag and irq on every clock, with the read address rotating so that all registers are observed.

// File: rtl/tmr16_cap_pkg.sv
package tmr16_cap_pkg;
    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CAPT  = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int CB_MODE  = 0;
    localparam int CB_SRC   = 1;
    localparam int CB_RUN   = 2;
    localparam int CB_CAPEN = 3;
    localparam int CB_OVF   = 7;

    localparam logic [7:0] CTRL_MASK = 8'h8F;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } lvl_state_t;

    typedef enum logic [1:0] {
        SRC_HALT,
        SRC_SYSCLK,
        SRC_DIV12,
        SRC_PIN
    } src_t;
endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect
    import tmr16_cap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    lvl_state_t        state_q;
    lvl_state_t        state_d;
    logic              lvl;

    assign lvl = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
        end
    end

    always_comb begin
        state_d = lvl ? LVL_HIGH : LVL_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fall = 1'b0;
        unique case (state_q)
            LVL_HIGH: fall = !lvl;
            LVL_LOW:  fall = 1'b0;
            default:  fall = 1'b0;
        endcase
    end

    // R6 / R7: one pulse per falling edge
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
    a_r7_pulse_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> state_q == LVL_LOW);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] ps_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ps_q <= '0;
                end else if (!run) begin
                    ps_q <= '0;
                end else if (ps_q == LAST) begin
                    ps_q <= '0;
                end else begin
                    ps_q <= ps_q + 1'b1;
                end
            end

            assign tick = run && (ps_q == LAST);

            // R5: prescaler restarts when idle; ticks are isolated
            a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> ps_q == '0);
            a_r5_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture
    import tmr16_cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             div12_sel,
    input  logic             irq_en,
    input  logic             cnt_pin,
    input  logic             cap_pin,
    output logic             irq
);
    localparam int PAD_W = CNT_W - 8;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [7:0]       ctrl_q;
    logic             run_cap;
    logic             cap_arm;
    logic             cnt_fall;
    logic             cap_fall;
    logic             ps_tick;
    logic             inc;
    logic             cnt_wr;
    logic             ctrl_wr;
    logic             ovf_now;
    logic             cap_fire;
    src_t             src;

    tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cnt_pin),
        .fall (cnt_fall)
    );

    tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_cap_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_pin),
        .fall (cap_fall)
    );

    tmr_prescale #(.DIV(PRESCALE)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_cap),
        .tick (ps_tick)
    );

    assign run_cap = ctrl_q[CB_MODE] && ctrl_q[CB_RUN];
    assign cap_arm = run_cap && ctrl_q[CB_CAPEN];

    always_comb begin
        if (!run_cap) begin
            src = SRC_HALT;
        end else if (ctrl_q[CB_SRC]) begin
            src = SRC_PIN;
        end else if (div12_sel) begin
            src = SRC_DIV12;
        end else begin
            src = SRC_SYSCLK;
        end
    end

    always_comb begin
        inc = 1'b0;
        unique case (src)
            SRC_HALT:   inc = 1'b0;
            SRC_SYSCLK: inc = 1'b1;
            SRC_DIV12:  inc = ps_tick;
            SRC_PIN:    inc = cnt_fall;
            default:    inc = 1'b0;
        endcase
    end

    assign cnt_wr   = wr_en && (addr == ADDR_COUNT);
    assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
    assign ovf_now  = inc && (&cnt_q) && !cnt_wr;
    assign cap_fire = cap_fall && cap_arm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_fire) begin
            cap_q <= cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= wdata[7:0] & CTRL_MASK;
            end
            if (ovf_now) begin
                ctrl_q[CB_OVF] <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_COUNT: rdata = cnt_q;
            ADDR_CAPT:  rdata = cap_q;
            ADDR_CTRL:  rdata = {{PAD_W{1'b0}}, ctrl_q};
            default:    rdata = '0;
        endcase
    end

    assign irq = ctrl_q[CB_OVF] && irq_en;

    // R3: counter holds while inactive and not written
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_cap && !cnt_wr) |=> $stable(cnt_q));
    // R7: capture takes the pre-step count
    a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cap_q == $past(cnt_q));
    // R8: disarmed capture leaves register alone
    a_r8_capture_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_arm |=> $stable(cap_q));
    // R9 / R10: wrap sets the flag regardless of a same-edge control write
    a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (&cnt_q) && !cnt_wr) |=> (ctrl_q[CB_OVF] && cnt_q == '0));
    // R11: interrupt requires enable
    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && ctrl_q[CB_OVF]));
    // R12: written value wins over a step
    a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: tb/tb_tmr16_capture.sv
`timescale 1ns/1ps
module tb_tmr16_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        div12_sel = 1'b0;
    logic        irq_en = 1'b0;
    logic        cnt_pin = 1'b1;
    logic        cap_pin = 1'b1;
    logic        irq;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    tmr16_capture dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .div12_sel(div12_sel),
        .irq_en   (irq_en),
        .cnt_pin  (cnt_pin),
        .cap_pin  (cap_pin),
        .irq      (irq)
    );

    // behavioural reference model
    logic [15:0] m_cnt, m_cap;
    logic [7:0]  m_ctrl;
    logic        m_c1, m_c2, m_cp, m_k1, m_k2, m_kp;
    int          m_ps;

    always @(posedge clk) begin : model
        logic run, cedge, kedge, tick, inc, cwr, ovf, fire;
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_ctrl = 0; m_ps = 0;
            m_c1 = 0; m_c2 = 0; m_cp = 0; m_k1 = 0; m_k2 = 0; m_kp = 0;
            armed = 1'b1;
        end else begin
            run   = m_ctrl[0] && m_ctrl[2];
            cedge = m_cp && !m_c2;
            kedge = m_kp && !m_k2;
            if (m_ctrl[1])      tick = cedge;
            else if (div12_sel) tick = (m_ps == 11);
            else                tick = 1'b1;
            inc  = run && tick;
            cwr  = wr_en && addr == 2'd0;
            fire = kedge && run && m_ctrl[3];
            ovf  = !cwr && inc && m_cnt == 16'hFFFF;
            if (fire) m_cap = m_cnt;
            if (cwr) m_cnt = wdata;
            else if (inc) m_cnt = m_cnt + 16'd1;
            if (wr_en && addr == 2'd2) m_ctrl = wdata[7:0] & 8'h8F;
            if (ovf) m_ctrl[7] = 1'b1;
            m_ps = !run ? 0 : (m_ps == 11 ? 0 : m_ps + 1);
            m_cp = m_c2; m_c2 = m_c1; m_c1 = cnt_pin;
            m_kp = m_k2; m_k2 = m_k1; m_k1 = cap_pin;
        end
    end

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return m_cap;
            2'd2:    return {8'h00, m_ctrl};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (armed && !done) begin
            vectors++;
            if (rdata !== exp_rd(addr) || irq !== (m_ctrl[7] && irq_en)) begin
                fails++;
                $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         phase, addr, rdata, irq, exp_rd(addr), m_ctrl[7] && irq_en);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired in %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0;
            addr = addr + 2'd1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1"; idle(4);

        phase = "R2"; irq_en = 1'b1;
        wr(2'd2, 16'hFFF0); idle(4);
        wr(2'd2, 16'h0000); wr(2'd1, 16'h1234); wr(2'd3, 16'hBEEF); idle(4);

        phase = "R3";
        wr(2'd0, 16'h0100); wr(2'd2, 16'h0004); idle(8);
        wr(2'd2, 16'h0001); idle(6);

        phase = "R4"; wr(2'd2, 16'h0005); idle(20);

        phase = "R7"; wr(2'd2, 16'h000D); idle(3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); cap_pin = 1'b0; idle(4);
            @(negedge clk); cap_pin = 1'b1; idle(5);
        end

        phase = "R8"; wr(2'd2, 16'h0005); idle(2);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); cap_pin = 1'b0; idle(4);
            @(negedge clk); cap_pin = 1'b1; idle(4);
        end

        phase = "R5"; div12_sel = 1'b1;
        wr(2'd2, 16'h0001); wr(2'd2, 16'h0005); idle(40);
        wr(2'd2, 16'h0001); idle(5);
        wr(2'd2, 16'h0005); idle(30);
        div12_sel = 1'b0;

        phase = "R6"; wr(2'd2, 16'h0007); idle(2);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); cnt_pin = 1'b0; idle(2 + (i % 3));
            @(negedge clk); cnt_pin = 1'b1; idle(3);
        end
        phase = "R7"; wr(2'd2, 16'h000F); idle(2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cnt_pin = 1'b0; cap_pin = 1'b0; idle(3);
            @(negedge clk); cnt_pin = 1'b1; cap_pin = 1'b1; idle(3);
        end

        phase = "R9"; wr(2'd2, 16'h0005); wr(2'd0, 16'hFFF8); idle(20);
        phase = "R11"; irq_en = 1'b0; idle(4); irq_en = 1'b1; idle(4);
        phase = "R9"; wr(2'd2, 16'h0005); idle(6);

        phase = "R10";
        wr(2'd0, 16'hFFFE); wr(2'd2, 16'h0005); wr(2'd2, 16'h0005); idle(6);
        wr(2'd2, 16'h0005); idle(3);

        phase = "R12";
        wr(2'd0, 16'hFFFF); wr(2'd0, 16'hFFFF); idle(6);
        wr(2'd0, 16'h7FFF); idle(4);

        phase = "R2"; wr(2'd2, 16'h0000); idle(6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule